// File: doc/BRIEF.md
# Programmable-Modulus Delta-Sigma Fractional Modulator

This block produces the per-cycle division offset for a fractional-N divider. It runs on the comparison clock. A programmed numerator and denominator set the fraction. The block adds a small signed offset to the integer divide word on every cycle, so that the long-run mean division equals the integer part plus NUM/DEN. Its accumulators wrap at the programmed denominator instead of at a power of two, so fractions such as 21/41 come out exactly.

Four first-order accumulator stages are chained. Each stage takes the residue of the stage before it. Their carries are combined in cascaded error-cancelling form, and the selected order picks how many stages reach the output: zero (integer mode), two, three or four. An optional pseudo-random dither bit can be mixed into the first stage's input. New settings take effect only on a load strobe, which also clears all modulator state.

Top module: `frac_mod_mash`

## Requirements
- R1: After the asynchronous reset, offset_o is 0 and the latched settings are integer mode with DEN=0. The num/den/order/dither inputs have no effect until a load.
- R2: The order field encodes order 0 as 0, order 2 as 1, order 3 as 2 and order 4 as 3. With order 0 latched, offset_o is always 0.
- R3: With a latched DEN of 0 or 1, offset_o is held at 0 for every order.
- R4: A high load_i at a rising edge latches num_i, den_i, order_i and dither_en_i, and clears every accumulator, delay and the dither register. offset_o reads 0 after that edge. Input changes without load_i have no effect.
- R5: offset_o is a 5-bit two's complement value. It stays within [-1,2] for order 2, [-3,4] for order 3 and [-7,8] for order 4.
- R6: Each stage adds its input to its state. A sum of DEN or more subtracts DEN and yields carry 1. Stage 1 takes NUM (plus dither), and stage k+1 takes stage k's new residue. With carries c1..c4, the offset is c1 + (1-z^-1)c2 + (1-z^-1)^2 c3 + (1-z^-1)^3 c4, truncated to the selected order. It appears on offset_o one cycle after the cycle it belongs to. For NUM=1, DEN=2 and order 2, the outputs after a load are 0,1,1,0 repeating.
- R7: Without dither, take the sum of the first n offsets after a load minus floor(n*NUM/DEN). It lies in [0,1] for order 2, [-1,2] for order 3 and [-3,4] for order 4, for any n. The mean therefore equals NUM/DEN exactly, and after every DEN cycles the sum is within that band of a whole multiple of NUM.
- R8: With dither enabled, a 23-bit maximal-length LFSR (x^23+x^18+1, seeded to 1 at reset and on load) adds its top bit to stage 1's input each cycle. The sequence then differs from the undithered one. The sum over the first m*DEN cycles stays within the R7 band of m*NUM, widened upward by m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Comparison clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Latch settings and clear modulator state |
| num_i | input | 22 | Fractional numerator, 0 to DEN-1 |
| den_i | input | 22 | Fractional denominator, 2 to 4194303 |
| order_i | input | 2 | Modulator order select (encoding in R2) |
| dither_en_i | input | 1 | Enable pseudo-random dither |
| offset_o | output | 5 | Signed per-cycle division offset |

## Verification
An exact 1/2 sequence pins down the stage wrap and the carry combination cycle by cycle. This is something the mean-value checks cannot see. The fraction 21/41 is run at orders 2, 3 and 4 to separate the cancellation terms by their band and range. A zero numerator, a tiny fraction (1/1000), a near-one fraction (2999/3000) and the full 22-bit denominator exercise the wrap arithmetic at its extremes. Integer mode, DEN=1, input changes without load and a mid-run reload show that settings apply only through the strobe. An undithered run and a dithered run of the same fraction are compared to show that the dither path alters the sequence while keeping the mean.

// File: rtl/frac_mod_pkg.sv
package frac_mod_pkg;
  localparam int unsigned ACC_W    = 22;
  localparam int unsigned NSTAGE   = 4;
  localparam int unsigned OUT_W    = 5;
  localparam int unsigned LFSR_W   = 23;
  localparam int unsigned LFSR_TAP = 18;

  typedef enum logic [1:0] {
    ORD_INT = 2'd0,
    ORD_2   = 2'd1,
    ORD_3   = 2'd2,
    ORD_4   = 2'd3
  } order_e;
endpackage

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int unsigned W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] den_i,
  input  logic [W:0]   add_i,
  output logic         carry_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] acc_o
);
  localparam int unsigned SW = W + 2;

  logic [W-1:0]  acc_q;
  logic [SW-1:0] sum;
  logic [SW-1:0] den_x;
  logic [SW-1:0] wrap;

  always_comb begin
    den_x   = {2'b00, den_i};
    sum     = {2'b00, acc_q} + {1'b0, add_i};
    wrap    = sum - den_x;
    carry_o = (sum >= den_x);
    res_o   = carry_o ? wrap[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= res_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/frac_lfsr.sv
module frac_lfsr #(
  parameter int unsigned W   = 23,
  parameter int unsigned TAP = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic         bit_o,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lfsr_q <= SEED;
    else if (clr_i) lfsr_q <= SEED;
    else            lfsr_q <= {lfsr_q[W-2:0], lfsr_q[W-1] ^ lfsr_q[TAP-1]};
  end

  assign bit_o   = lfsr_q[W-1];
  assign state_o = lfsr_q;
endmodule

// File: rtl/frac_noise_comb.sv
module frac_noise_comb
  import frac_mod_pkg::*;
#(
  parameter int unsigned OUT_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic [3:0]              carry_i,
  input  order_e                  order_i,
  input  logic                    active_i,
  output logic signed [OUT_W-1:0] off_o
);
  localparam int unsigned SW = OUT_W + 2;

  // delayed carries: c2 z^-1, c3 z^-1..z^-2, c4 z^-1..z^-3
  logic       c2_h;
  logic [1:0] c3_h;
  logic [2:0] c4_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_h <= 1'b0;
      c3_h <= '0;
      c4_h <= '0;
    end else if (clr_i) begin
      c2_h <= 1'b0;
      c3_h <= '0;
      c4_h <= '0;
    end else begin
      c2_h <= carry_i[1];
      c3_h <= {c3_h[0], carry_i[2]};
      c4_h <= {c4_h[1:0], carry_i[3]};
    end
  end

  function automatic logic signed [SW-1:0] ext(input logic b);
    return {{(SW-1){1'b0}}, b};
  endfunction

  logic signed [SW-1:0] t1, t2, t3, t4, tot;

  always_comb begin
    t1 = ext(carry_i[0]);
    t2 = ext(carry_i[1]) - ext(c2_h);
    t3 = ext(carry_i[2]) - (ext(c3_h[0]) <<< 1) + ext(c3_h[1]);
    t4 = ext(carry_i[3]) - ((ext(c4_h[0]) <<< 1) + ext(c4_h[0]))
       + ((ext(c4_h[1]) <<< 1) + ext(c4_h[1])) - ext(c4_h[2]);
    unique case (order_i)
      ORD_2:   tot = t1 + t2;
      ORD_3:   tot = t1 + t2 + t3;
      ORD_4:   tot = t1 + t2 + t3 + t4;
      default: tot = '0;
    endcase
    if (!active_i) tot = '0;
    off_o = tot[OUT_W-1:0];
  end
endmodule

// File: rtl/frac_mod_mash.sv
module frac_mod_mash
  import frac_mod_pkg::*;
#(
  parameter int unsigned ACC_W    = frac_mod_pkg::ACC_W,
  parameter int unsigned OUT_W    = frac_mod_pkg::OUT_W,
  parameter int unsigned LFSR_W   = frac_mod_pkg::LFSR_W,
  parameter int unsigned LFSR_TAP = frac_mod_pkg::LFSR_TAP
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [ACC_W-1:0]        num_i,
  input  logic [ACC_W-1:0]        den_i,
  input  logic [1:0]              order_i,
  input  logic                    dither_en_i,
  output logic signed [OUT_W-1:0] offset_o
);
  localparam int unsigned ACC_FLAT = NSTAGE * ACC_W;

  logic [ACC_W-1:0] num_q, den_q;
  order_e           order_q;
  logic             dith_q;
  logic             active;
  logic             lfsr_bit;
  logic [LFSR_W-1:0] lfsr_state;

  logic [ACC_W:0]    stage_in  [NSTAGE];
  logic [ACC_W-1:0]  stage_res [NSTAGE];
  logic [NSTAGE-1:0] carry;
  logic [ACC_FLAT-1:0] acc_flat;

  logic signed [OUT_W-1:0] off_d, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q   <= '0;
      den_q   <= '0;
      order_q <= ORD_INT;
      dith_q  <= 1'b0;
    end else if (load_i) begin
      num_q   <= num_i;
      den_q   <= den_i;
      order_q <= order_e'(order_i);
      dith_q  <= dither_en_i;
    end
  end

  assign active = (den_q > ACC_W'(1)) && (order_q != ORD_INT);

  frac_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_i),
    .bit_o   (lfsr_bit),
    .state_o (lfsr_state)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_in[g] = {1'b0, num_q} + {{ACC_W{1'b0}}, dith_q & lfsr_bit};
    end else begin : g_next
      assign stage_in[g] = {1'b0, stage_res[g-1]};
    end

    frac_acc_stage #(.W(ACC_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (load_i),
      .den_i   (den_q),
      .add_i   (stage_in[g]),
      .carry_o (carry[g]),
      .res_o   (stage_res[g]),
      .acc_o   (acc_flat[g*ACC_W +: ACC_W])
    );
  end

  frac_noise_comb #(.OUT_W(OUT_W)) u_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load_i),
    .carry_i  (carry),
    .order_i  (order_q),
    .active_i (active),
    .off_o    (off_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (load_i) off_q <= '0;
    else             off_q <= off_d;
  end

  assign offset_o = off_q;
endmodule

// File: rtl/frac_mod_mash_chk.sv
module frac_mod_mash_chk #(
  parameter int unsigned ACC_W  = 22,
  parameter int unsigned OUT_W  = 5,
  parameter int unsigned NST    = 4,
  parameter int unsigned LFSR_W = 23
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    load_i,
  input logic signed [OUT_W-1:0] offset_o,
  input logic [ACC_W-1:0]        num_q,
  input logic [ACC_W-1:0]        den_q,
  input logic [1:0]              order_q,
  input logic [NST*ACC_W-1:0]    acc_flat,
  input logic [LFSR_W-1:0]       lfsr_state
);
  AST_INT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_q == 2'd0) |-> (offset_o == '0)); // R2

  AST_DEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_q < ACC_W'(2)) |-> (offset_o == '0)); // R3

  AST_LOAD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (offset_o == '0)); // R4

  AST_RANGE_O2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_q == 2'd1) |-> (offset_o >= -1 && offset_o <= 2)); // R5

  AST_RANGE_O3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_q == 2'd2) |-> (offset_o >= -3 && offset_o <= 4)); // R5

  AST_RANGE_O4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_q == 2'd3) |-> (offset_o >= -7 && offset_o <= 8)); // R5

  for (genvar s = 0; s < NST; s++) begin : g_acc
    AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (den_q >= ACC_W'(2) && num_q < den_q) |-> (acc_flat[s*ACC_W +: ACC_W] < den_q)); // R6
  end

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0); // R8
endmodule

bind frac_mod_mash frac_mod_mash_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .NST(frac_mod_pkg::NSTAGE), .LFSR_W(LFSR_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .offset_o   (offset_o),
  .num_q      (num_q),
  .den_q      (den_q),
  .order_q    (order_q),
  .acc_flat   (acc_flat),
  .lfsr_state (lfsr_state)
);

// File: tb/frac_mod_mash_tb_top.sv
`timescale 1ns/1ps
module frac_mod_mash_tb_top;
  logic              clk = 1'b0;
  logic              rst_ni;
  logic              load_i;
  logic [21:0]       num_i, den_i;
  logic [1:0]        order_i;
  logic              dither_en_i;
  logic signed [4:0] offset_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  frac_mod_mash dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .num_i(num_i),
    .den_i(den_i), .order_i(order_i), .dither_en_i(dither_en_i),
    .offset_o(offset_o)
  );

  typedef struct packed {
    int num; int den; int ord; int win; int reps;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{21, 41, 1, 41, 20},
    '{21, 41, 2, 41, 20},
    '{21, 41, 3, 41, 20},
    '{6, 7, 1, 7, 30},
    '{0, 7, 3, 7, 20},
    '{1, 1000, 3, 1000, 3},
    '{2999, 3000, 2, 500, 8},
    '{4194302, 4194303, 3, 50, 4},
    '{5, 1, 1, 16, 8},
    '{5, 16, 0, 16, 8}
  };

  function automatic int band_lo(input int o);
    return (o == 1) ? 0 : (o == 2) ? -1 : (o == 3) ? -3 : 0;
  endfunction
  function automatic int band_hi(input int o);
    return (o == 1) ? 1 : (o == 2) ? 2 : (o == 3) ? 4 : 0;
  endfunction
  function automatic int rng_lo(input int o);
    return (o == 1) ? -1 : (o == 2) ? -3 : (o == 3) ? -7 : 0;
  endfunction
  function automatic int rng_hi(input int o);
    return (o == 1) ? 2 : (o == 2) ? 4 : (o == 3) ? 8 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  // returns offset sampled right after the load edge
  task automatic do_load(input int num, input int den, input int ord,
                         input bit dith, output int y0);
    @(negedge clk);
    load_i = 1'b1; num_i = 22'(num); den_i = 22'(den);
    order_i = 2'(ord); dither_en_i = dith;
    @(negedge clk);
    load_i = 1'b0;
    y0 = int'(offset_o);
  endtask

  task automatic sample(output int y);
    @(negedge clk);
    y = int'(offset_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int y, y0;
    int nz;
    int ref_seq [64];
    int diffs;
    longint s;

    rst_ni = 1'b0; load_i = 1'b0; num_i = '0; den_i = '0;
    order_i = '0; dither_en_i = 1'b0;
    repeat (3) @(negedge clk);
    check(offset_o == 0, "R1", "offset in reset", offset_o, 0);
    rst_ni = 1'b1;

    // R1: inputs without load have no effect after reset
    num_i = 22'd21; den_i = 22'd41; order_i = 2'd3;
    nz = 0;
    for (int i = 0; i < 40; i++) begin sample(y); if (y != 0) nz++; end
    check(nz == 0, "R1", "nonzero outputs before load", nz, 0);

    // R6: exact 1/2 order-2 sequence 0,1,1,0
    do_load(1, 2, 1, 1'b0, y0);
    check(y0 == 0, "R4", "offset after load edge", y0, 0);
    for (int i = 0; i < 8; i++) begin
      int e;
      e = ((i % 4) == 1 || (i % 4) == 2) ? 1 : 0;
      sample(y);
      check(y == e, "R6", $sformatf("1/2 seq idx %0d", i), y, e);
    end

    // table walk: R7 band, R5 range, R2/R3 zero modes
    for (int v = 0; v < NVEC; v++) begin
      bit zmode;
      int bad_rng;
      longint n;
      zmode = (VECS[v].ord == 0) || (VECS[v].den < 2);
      do_load(VECS[v].num, VECS[v].den, VECS[v].ord, 1'b0, y0);
      s = 0; n = 0; bad_rng = 0;
      for (int r = 1; r <= VECS[v].reps; r++) begin
        longint base, dev;
        for (int c = 0; c < VECS[v].win; c++) begin
          sample(y);
          s += y; n++;
          if (y < rng_lo(VECS[v].ord) || y > rng_hi(VECS[v].ord)) bad_rng++;
        end
        if (zmode) begin
          check(s == 0, VECS[v].ord == 0 ? "R2" : "R3",
                $sformatf("vec %0d zero-mode sum", v), s, 0);
        end else begin
          base = (n * longint'(VECS[v].num)) / longint'(VECS[v].den);
          dev = s - base;
          check(dev >= band_lo(VECS[v].ord) && dev <= band_hi(VECS[v].ord), "R7",
                $sformatf("vec %0d window %0d sum", v, r), s, base);
        end
      end
      check(bad_rng == 0, "R5", $sformatf("vec %0d out-of-range samples", v), bad_rng, 0);
    end

    // R4: input changes without load are ignored
    do_load(21, 41, 2, 1'b0, y0);
    num_i = 22'd3; den_i = 22'd5; order_i = 2'd0; dither_en_i = 1'b1;
    s = 0;
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 41; c++) begin sample(y); s += y; end
      check(s - r * 21 >= -1 && s - r * 21 <= 2, "R4",
            $sformatf("ignored inputs window %0d", r), s, r * 21);
    end

    // R4: mid-run reload clears state
    do_load(1, 2, 1, 1'b0, y0);
    check(y0 == 0, "R4", "offset after mid-run reload", y0, 0);
    sample(y);
    check(y == 0, "R4", "first offset after reload", y, 0);
    sample(y);
    check(y == 1, "R4", "second offset after reload", y, 1);

    // R8: dither changes the sequence, keeps the mean
    do_load(21, 41, 1, 1'b0, y0);
    for (int i = 0; i < 64; i++) begin sample(y); ref_seq[i] = y; end
    do_load(21, 41, 1, 1'b1, y0);
    diffs = 0; s = 0;
    for (int i = 0; i < 64; i++) begin
      sample(y); s += y;
      if (y != ref_seq[i]) diffs++;
    end
    check(diffs > 0, "R8", "dithered differs from plain", diffs, 1);
    do_load(21, 41, 1, 1'b1, y0);
    s = 0;
    for (int r = 1; r <= 20; r++) begin
      for (int c = 0; c < 41; c++) begin sample(y); s += y; end
      check(s >= r * 21 && s <= r * 21 + 1 + r, "R8",
            $sformatf("dithered window %0d", r), s, r * 21);
    end

    summary();
    $finish;
  end
endmodule